// File: doc/BRIEF.md
# Time-protected system option register

An 8-bit configuration register that sets a few system-wide options from one bus write port. Its contents are always visible on a read port. Three of its fields are guarded in normal mode. Those fields accept exactly one write, and only during a short window that opens when reset is released. After that write, or after the window closes, they are frozen until the next reset. A mode input selects special operation, which removes the guard so those fields can be rewritten at any time. The clock-monitor field is never guarded.

The register also drives two small engines. The STOP-recovery engine is a state machine with the states D_IDLE, D_WAIT and D_RESUME. A `stop_exit` pulse moves it from D_IDLE to D_WAIT and loads a long or a short delay, chosen by the delay-enable field. When the count runs out it moves to D_RESUME, which gives a one-cycle `resume` pulse, and then returns to D_IDLE. The IRQ conditioning engine passes the active-low IRQ pin through as a registered level in level mode. In edge mode it uses the states I_IDLE and I_PEND. A falling edge moves it from I_IDLE to I_PEND, and `irq_ack` moves it back to I_IDLE.

The guard is a two-state machine. In L_OPEN a window counter runs. L_OPEN moves to L_LOCKED on the first write, or when the counter reaches its last window cycle.

Top module: `sysopt_reg`

## Requirements
- R1: After reset the read value is 0x10. The field positions are: bit 5 is IRQ edge select, bit 4 is STOP-exit delay enable, bit 3 is clock-monitor enable, and bits 1:0 are the watchdog rate code.
- R2: In normal mode (`special_mode`=0), the guarded fields (bits 5, 4, 1, 0) accept a write only at clock edges 0 through 63 after reset is released. A write at edge 64 or later leaves them unchanged.
- R3: In normal mode, only the first write inside the window updates the guarded fields. Every later write leaves them unchanged.
- R4: In special mode (`special_mode`=1), the guarded fields take every write, at any time.
- R5: Bits 7, 6 and 2 always read as zero, whatever is written.
- R6: Bit 3 takes every write, even in a write whose guarded fields are ignored.
- R7: When delay enable is 1, `resume` is asserted 4096 clock cycles after the edge that samples `stop_exit`.
- R8: When delay enable is 0, that delay is 4 cycles. `resume` is high for exactly one cycle.
- R9: `wdog_factor` is 1, 4, 16 or 64 for rate codes 0, 1, 2 and 3.
- R10: In edge mode, a falling edge on `irq_n` makes `irq_req` high one cycle later. It stays high until `irq_ack` is sampled. A pin that is held low does not raise it again.
- R11: In level mode, `irq_req` equals the inverse of `irq_n` as sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| special_mode | input | 1 | 1 removes the one-time write guard |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register value |
| irq_edge_sel | output | 1 | 1 selects falling-edge IRQ |
| stop_dly_en | output | 1 | 1 selects the long STOP-exit delay |
| clkmon_en | output | 1 | Clock monitor enable |
| wdog_rate | output | 2 | Watchdog rate code |
| wdog_factor | output | 7 | Watchdog divider factor |
| stop_exit | input | 1 | Pulse that starts STOP recovery |
| resume | output | 1 | One-cycle pulse when recovery ends |
| irq_n | input | 1 | Raw IRQ pin, active low |
| irq_ack | input | 1 | Clears a pending edge IRQ |
| irq_req | output | 1 | Conditioned IRQ request |

## Verification
The bench writes at edge 63 and at edge 64 after reset. A guard counter that is off by one would accept the late write or reject the last legal one. It writes twice inside the window and checks that a second guarded write is rejected while bit 3 still changes. A lock that also froze bit 3, or that never engaged, shows up as a wrong read value. It measures both STOP-exit delays to the exact cycle and checks that the pulse is one cycle wide, which catches a counter that loads the wrong length. In edge mode it releases the pin and holds it low around an acknowledge, which exposes a level-triggered or self-clearing pending flag.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
    localparam int REG_W     = 8;
    localparam int RATE_W    = 2;
    localparam int FACTOR_W  = 2 * ((1 << RATE_W) - 1) + 1;
    localparam int BIT_IRQE  = 5;
    localparam int BIT_DLY   = 4;
    localparam int BIT_CME   = 3;
    localparam logic [REG_W-1:0] RESET_VAL = 8'h10;

    typedef enum logic {L_OPEN, L_LOCKED} lock_st_t;
    typedef enum logic [1:0] {D_IDLE, D_WAIT, D_RESUME} dly_st_t;
    typedef enum logic {I_IDLE, I_PEND} irq_st_t;
endpackage

// File: rtl/sysopt_lock.sv
module sysopt_lock #(
    parameter int WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic special_mode,
    input  logic wr_en,
    output logic prot_ok
);
    import sysopt_pkg::*;
    localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    lock_st_t st_q, st_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= L_OPEN;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == L_OPEN) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            L_OPEN:   if (wr_en || cnt_q == LAST) st_d = L_LOCKED;
            L_LOCKED: st_d = L_LOCKED;
        endcase
    end

    always_comb begin
        prot_ok = special_mode || (st_q == L_OPEN);
    end
endmodule

// File: rtl/sysopt_stopdly.sv
module sysopt_stopdly #(
    parameter int LONG_CYC  = 4096,
    parameter int SHORT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dly_en,
    input  logic stop_exit,
    output logic resume
);
    import sysopt_pkg::*;
    localparam int CW = $clog2(LONG_CYC + 1);

    dly_st_t st_q, st_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= D_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == D_IDLE && stop_exit)
                cnt_q <= dly_en ? CW'(LONG_CYC) : CW'(SHORT_CYC);
            else if (st_q == D_WAIT)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            D_IDLE:   if (stop_exit) st_d = D_WAIT;
            D_WAIT:   if (cnt_q == CW'(1)) st_d = D_RESUME;
            D_RESUME: st_d = D_IDLE;
            default:  st_d = D_IDLE;
        endcase
    end

    always_comb begin
        resume = (st_q == D_RESUME);
    end
endmodule

// File: rtl/sysopt_irqcond.sv
module sysopt_irqcond (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_sel,
    input  logic irq_n,
    input  logic irq_ack,
    output logic irq_req
);
    import sysopt_pkg::*;

    irq_st_t st_q, st_d;
    logic    pin_q;
    logic    fall;

    always_comb fall = pin_q && !irq_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= I_IDLE;
            pin_q <= 1'b1;
        end else begin
            st_q  <= st_d;
            pin_q <= irq_n;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            I_IDLE: if (fall) st_d = I_PEND;
            I_PEND: if (irq_ack && !fall) st_d = I_IDLE;
        endcase
    end

    always_comb begin
        irq_req = edge_sel ? (st_q == I_PEND) : !pin_q;
    end
endmodule

// File: rtl/sysopt_reg.sv
module sysopt_reg #(
    parameter int WINDOW    = 64,
    parameter int LONG_CYC  = 4096,
    parameter int SHORT_CYC = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             special_mode,
    input  logic                             wr_en,
    input  logic [sysopt_pkg::REG_W-1:0]     wr_data,
    output logic [sysopt_pkg::REG_W-1:0]     rd_data,
    output logic                             irq_edge_sel,
    output logic                             stop_dly_en,
    output logic                             clkmon_en,
    output logic [sysopt_pkg::RATE_W-1:0]    wdog_rate,
    output logic [sysopt_pkg::FACTOR_W-1:0]  wdog_factor,
    input  logic                             stop_exit,
    output logic                             resume,
    input  logic                             irq_n,
    input  logic                             irq_ack,
    output logic                             irq_req
);
    import sysopt_pkg::*;

    logic                prot_ok;
    logic                irqe_q, dly_q, cme_q;
    logic [RATE_W-1:0]   rate_q;
    logic [2:0]          unused_bits;

    assign unused_bits = {wr_data[7], wr_data[6], wr_data[2]};

    sysopt_lock #(.WINDOW(WINDOW)) u_lock (
        .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
        .wr_en(wr_en), .prot_ok(prot_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irqe_q <= RESET_VAL[BIT_IRQE];
            dly_q  <= RESET_VAL[BIT_DLY];
            cme_q  <= RESET_VAL[BIT_CME];
            rate_q <= RESET_VAL[RATE_W-1:0];
        end else if (wr_en) begin
            cme_q <= wr_data[BIT_CME];
            if (prot_ok) begin
                irqe_q <= wr_data[BIT_IRQE];
                dly_q  <= wr_data[BIT_DLY];
                rate_q <= wr_data[RATE_W-1:0];
            end
        end
    end

    always_comb begin
        rd_data                = '0;
        rd_data[BIT_IRQE]      = irqe_q;
        rd_data[BIT_DLY]       = dly_q;
        rd_data[BIT_CME]       = cme_q;
        rd_data[RATE_W-1:0]    = rate_q;
        irq_edge_sel           = irqe_q;
        stop_dly_en            = dly_q;
        clkmon_en              = cme_q;
        wdog_rate              = rate_q;
        wdog_factor            = FACTOR_W'(1) << {rate_q, 1'b0};
    end

    sysopt_stopdly #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_dly (
        .clk(clk), .rst_n(rst_n), .dly_en(dly_q),
        .stop_exit(stop_exit), .resume(resume)
    );

    sysopt_irqcond u_irq (
        .clk(clk), .rst_n(rst_n), .edge_sel(irqe_q),
        .irq_n(irq_n), .irq_ack(irq_ack), .irq_req(irq_req)
    );
endmodule

// File: rtl/sysopt_chk.sv
module sysopt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       special_mode,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       irq_edge_sel,
    input logic       clkmon_en,
    input logic [6:0] wdog_factor,
    input logic       resume,
    input logic       irq_n,
    input logic       irq_ack,
    input logic       irq_req,
    input logic       prot_ok
);
    a_r5_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b00 && rd_data[2] == 1'b0);

    a_r3_guard_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!special_mode && !prot_ok && wr_en) |=> $stable({rd_data[5:4], rd_data[1:0]}));

    a_r6_cme_writes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> clkmon_en == $past(wr_data[3]));

    a_r8_resume_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);

    a_r9_factor_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wdog_factor) == 1);

    a_r10_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_edge_sel && irq_req && !irq_ack && !wr_en) |=> irq_req);

    a_r11_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_edge_sel && !wr_en) |=> (irq_req == !$past(irq_n)));
endmodule

bind sysopt_reg sysopt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_edge_sel(irq_edge_sel),
    .clkmon_en(clkmon_en), .wdog_factor(wdog_factor), .resume(resume),
    .irq_n(irq_n), .irq_ack(irq_ack), .irq_req(irq_req), .prot_ok(prot_ok)
);

// File: tb/sysopt_reg_bench.sv
module sysopt_reg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // each entry: {write data, expected read value} in special mode
    localparam logic [15:0] VEC [NVEC] = '{
        16'hFF_3B, 16'h00_00, 16'hC4_00, 16'h21_21,
        16'h12_12, 16'h0B_0B, 16'h33_33
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic special_mode = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic irq_edge_sel, stop_dly_en, clkmon_en, resume, irq_req;
    logic [1:0] wdog_rate;
    logic [6:0] wdog_factor;
    logic stop_exit = 1'b0;
    logic irq_n = 1'b1;
    logic irq_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysopt_reg u_sysopt_reg (
        .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq_edge_sel(irq_edge_sel), .stop_dly_en(stop_dly_en),
        .clkmon_en(clkmon_en), .wdog_rate(wdog_rate),
        .wdog_factor(wdog_factor), .stop_exit(stop_exit),
        .resume(resume), .irq_n(irq_n), .irq_ack(irq_ack),
        .irq_req(irq_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic spec);
        rst_n = 1'b0;
        special_mode = spec;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic stop_delay(input string req, input int exp_cyc);
        int n;
        stop_exit = 1'b1;
        @(negedge clk);
        stop_exit = 1'b0;
        n = 1;
        while (!resume && n < 6000) begin
            @(negedge clk);
            n++;
        end
        check(req, n - 1, exp_cyc);
        @(negedge clk);
        check("R8 pulse width", int'(resume), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset value and field mapping
        do_reset(1'b0);
        check("R1 reset value", int'(rd_data), 'h10);
        check("R1 delay enable out", int'(stop_dly_en), 1);
        check("R9 factor at code 0", int'(wdog_factor), 1);

        // R2/R3/R6: first write in window, then a second one
        wr(8'h2B);
        check("R2 write at edge 0", int'(rd_data), 'h2B);
        check("R9 factor at code 3", int'(wdog_factor), 64);
        wr(8'h10);
        check("R3 second write guarded", int'(rd_data), 'h23);
        check("R6 clock monitor still written", int'(clkmon_en), 0);

        // R2: last legal edge
        do_reset(1'b0);
        idle(63);
        wr(8'h03);
        check("R2 write at edge 63", int'(rd_data), 'h03);

        // R2/R6: first edge past the window
        do_reset(1'b0);
        idle(64);
        wr(8'h2B);
        check("R2 write at edge 64 ignored", int'(rd_data), 'h18);

        // R7: long STOP-exit delay with reset default
        do_reset(1'b0);
        stop_delay("R7 long delay", 4096);

        // R4/R5/R9: special mode table
        do_reset(1'b1);
        idle(80);
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][15:8]);
            check("R4 R5 special write", int'(rd_data), int'(VEC[i][7:0]));
            check("R9 factor", int'(wdog_factor), 1 << (2 * VEC[i][1:0]));
        end

        // R8: short delay after clearing delay enable
        wr(8'h00);
        stop_delay("R8 short delay", 4);

        // R11: level mode
        do_reset(1'b0);
        irq_n = 1'b0;
        @(negedge clk);
        check("R11 level asserted", int'(irq_req), 1);
        irq_n = 1'b1;
        @(negedge clk);
        check("R11 level released", int'(irq_req), 0);

        // R10: edge mode
        do_reset(1'b0);
        wr(8'h20);
        irq_n = 1'b0;
        @(negedge clk);
        check("R10 edge captured", int'(irq_req), 1);
        irq_n = 1'b1;
        idle(3);
        check("R10 pending held", int'(irq_req), 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R10 ack clears", int'(irq_req), 0);
        irq_n = 1'b0;
        @(negedge clk);
        check("R10 second edge", int'(irq_req), 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        idle(3);
        check("R10 held low no retrigger", int'(irq_req), 0);
        irq_n = 1'b1;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule